// File: doc/BRIEF.md
# Flash Program/Erase Host Sequencer

This block sits on the host side of a 16-bit asynchronous parallel NOR flash bus. A client hands it one request at a time over a valid/ready handshake. The request can be: program one word, erase a sector, erase a block, erase the whole array, or fetch the two identification words. The sequencer turns the request into the unlock and command write cycles the flash expects. For program and erase it then polls the device status until the internal operation has finished or a per-operation time limit runs out. It ends every request with a single-cycle response pulse that carries an error flag and, for an identification request, the two words read.

Bus timing is abstracted. Each access holds a chip-select strobe for a fixed number of clocks (`ACC_CLKS`), with address, write data and direction held constant. Read data is sampled in the last clock of the access. Completion is found by watching status bit 6, which toggles while the device is busy. A candidate end is then confirmed by two more reads, so that a read landing at the very moment the device finishes is not taken as a final answer.

Top module: `flash_seq`

## Requirements
- R1: After reset `req_ready` is 1, `bus_cs` is 0 and `rsp_valid` is 0.
- R2: A program request (`req_op` = 0) writes, in order: 00AAh to 5555h, 0055h to 2AAAh, 00A0h to 5555h, then `req_data` to `req_addr`.
- R3: An erase request writes, in order: 00AAh to 5555h, 0055h to 2AAAh, 0080h to 5555h, 00AAh to 5555h, 0055h to 2AAAh, then a final command word. The final word is 0030h to `req_addr` for a sector (`req_op` = 1), 0050h to `req_addr` for a block (`req_op` = 2), or 0010h to 5555h for the whole array (`req_op` = 3).
- R4: No status read is issued before the last command write of a program or erase. All status reads go to `req_addr`, except for the whole-array erase, whose status reads go to 5555h.
- R5: A request succeeds (`rsp_err` = 0) only after all of the following. Two consecutive status reads return the same bit 6. Then two further reads each return bit 6 equal to the read before them and a valid bit 7. Bit 7 is valid when it equals bit 7 of `req_data` for a program, and when it is 1 for an erase. If either further read fails, polling goes on.
- R6: Polling is limited to `TO_PROG` clocks for a program, `TO_ERASE` for a sector or block erase and `TO_CHIP` for the whole array. These clocks are counted from the first status read. When the limit is reached, the sequencer writes 00F0h to 5555h after the read in progress completes, then responds with `rsp_err` = 1.
- R7: An identification request (`req_op` = 4) writes 00AAh to 5555h, 0055h to 2AAAh and 0090h to 5555h. It then reads address 0 and address 1, and writes 00F0h to 5555h. It responds with `rsp_data` = {word at address 1, word at address 0} and `rsp_err` = 0.
- R8: `req_ready` is 1 only when no request is in progress. It falls in the cycle after a request is accepted and stays low until the response. `req_valid` presented while it is low has no effect on the bus.
- R9: Every bus access holds `bus_cs` high for exactly `ACC_CLKS` clocks, with `bus_addr`, `bus_we` and `bus_wdata` constant. There is at least one clock with `bus_cs` low between accesses.
- R10: Operation codes 5, 6 and 7 produce a response with `rsp_err` = 1 and no bus access.
- R11: `rsp_valid` is a single-cycle pulse, and `rsp_err` is 1 only while `rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 3 | 0 program, 1 sector erase, 2 block erase, 3 array erase, 4 identification |
| req_addr | input | AW | Target word address |
| req_data | input | 16 | Word to program |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request failed (timeout or bad code) |
| rsp_data | output | 32 | Identification words {addr 1, addr 0} |
| bus_cs | output | 1 | Access strobe to the flash |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Flash word address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data from the flash |

## Verification
The assertions assume that reset is applied before the first request and that `bus_rdata` stays constant for the whole of a read access. They also assume that the flash ignores writes while it is busy, so a timeout write cannot change a poll already in flight. The bench's behavioural flash changes its toggle state and busy phase only after `bus_cs` falls, and it ignores commands while busy. Its identification words and busy length are set per request, and a stall option repeats one bit-6 value so that a false candidate reaches the confirmation reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_PROG  = 3'd0,
    OP_SECT  = 3'd1,
    OP_BLOCK = 3'd2,
    OP_CHIP  = 3'd3,
    OP_ID    = 3'd4,
    OP_BAD5  = 3'd5,
    OP_BAD6  = 3'd6,
    OP_BAD7  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    AS_KEY1,
    AS_KEY2,
    AS_TARGET,
    AS_WORD0,
    AS_WORD1
  } asel_e;

  typedef struct packed {
    logic       wr;
    asel_e      asel;
    logic       use_data;
    logic [7:0] code;
  } step_t;

  localparam logic [14:0] KEY1_ADDR = 15'h5555;
  localparam logic [14:0] KEY2_ADDR = 15'h2AAA;
  localparam logic [7:0]  CMD_RESET = 8'hF0;

  // number of script entries per operation; 0 marks an unsupported code
  function automatic logic [2:0] script_len(op_e op);
    case (op)
      OP_PROG:                   return 3'd4;
      OP_SECT, OP_BLOCK, OP_CHIP: return 3'd6;
      OP_ID:                     return 3'd6;
      default:                   return 3'd0;
    endcase
  endfunction

  function automatic logic op_is_erase(op_e op);
    return (op == OP_SECT) || (op == OP_BLOCK) || (op == OP_CHIP);
  endfunction

  function automatic logic [7:0] erase_code(op_e op);
    case (op)
      OP_SECT:  return 8'h30;
      OP_BLOCK: return 8'h50;
      default:  return 8'h10;
    endcase
  endfunction

  // 0: program limit, 1: sector/block limit, 2: array limit
  function automatic logic [1:0] tmo_class(op_e op);
    case (op)
      OP_PROG:           return 2'd0;
      OP_SECT, OP_BLOCK: return 2'd1;
      default:           return 2'd2;
    endcase
  endfunction

  function automatic step_t script_step(op_e op, logic [2:0] idx);
    step_t s;
    s.wr       = 1'b1;
    s.asel     = AS_KEY1;
    s.use_data = 1'b0;
    s.code     = 8'hAA;
    case (idx)
      3'd1: begin
        s.asel = AS_KEY2;
        s.code = 8'h55;
      end
      3'd2: s.code = (op == OP_PROG) ? 8'hA0 : ((op == OP_ID) ? 8'h90 : 8'h80);
      3'd3: begin
        if (op == OP_PROG) begin
          s.asel     = AS_TARGET;
          s.use_data = 1'b1;
        end else if (op == OP_ID) begin
          s.wr   = 1'b0;
          s.asel = AS_WORD0;
        end
      end
      3'd4: begin
        if (op == OP_ID) begin
          s.wr   = 1'b0;
          s.asel = AS_WORD1;
        end else begin
          s.asel = AS_KEY2;
          s.code = 8'h55;
        end
      end
      3'd5: begin
        if (op == OP_ID) begin
          s.code = CMD_RESET;
        end else begin
          s.asel = (op == OP_CHIP) ? AS_KEY1 : AS_TARGET;
          s.code = erase_code(op);
        end
      end
      default: ;
    endcase
    return s;
  endfunction

  // confirmation read: bit 6 held still and bit 7 shows the finished value
  function automatic logic conf_valid(logic erase, logic [15:0] cur,
                                      logic [15:0] prev, logic want7);
    return (cur[6] == prev[6]) && (erase ? cur[7] : (cur[7] == want7));
  endfunction

endpackage

// File: rtl/flash_seq_access.sv
module flash_seq_access #(
  parameter int AW       = 18,
  parameter int ACC_CLKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic          busy,
  output logic          last,
  output logic          bus_cs,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata
);
  localparam int CW = (ACC_CLKS < 2) ? 1 : $clog2(ACC_CLKS);

  logic [CW-1:0] cnt;

  assign last   = busy && (cnt == CW'(ACC_CLKS - 1));
  assign bus_cs = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        cnt       <= '0;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int unsigned TO_PROG  = 6400,
  parameter int unsigned TO_ERASE = 6400000,
  parameter int unsigned TO_CHIP  = 25600000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] cls,
  output logic       expired
);
  localparam int unsigned MAX_A = (TO_PROG > TO_ERASE) ? TO_PROG : TO_ERASE;
  localparam int unsigned MAX_L = (MAX_A > TO_CHIP) ? MAX_A : TO_CHIP;
  localparam int TW = $clog2(MAX_L + 2);

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  always_comb begin
    case (cls)
      2'd0:    limit = TW'(TO_PROG);
      2'd1:    limit = TW'(TO_ERASE);
      default: limit = TW'(TO_CHIP);
    endcase
  end

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status
  import flash_seq_pkg::*;
(
  input  logic [15:0] cur,
  input  logic [15:0] prev,
  input  logic        erase,
  input  logic        want7,
  output logic        b6_same,
  output logic        conf_ok
);
  assign b6_same = (cur[6] == prev[6]);
  assign conf_ok = conf_valid(erase, cur, prev, want7);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int          AW       = 18,
  parameter int          ACC_CLKS = 4,
  parameter int unsigned TO_PROG  = 6400,
  parameter int unsigned TO_ERASE = 6400000,
  parameter int unsigned TO_CHIP  = 25600000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_data,
  output logic          bus_cs,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_SCRIPT, S_POLL, S_ABORT, S_RESP} state_e;

  state_e        state;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [15:0]   prev_q;
  logic [15:0]   id_lo, id_hi;
  logic [2:0]    step;
  logic [1:0]    pphase;
  logic          err_q;

  // named internal events
  logic          accept;
  logic          acc_start, acc_busy, acc_done;
  logic          acc_we;
  logic [AW-1:0] acc_addr;
  logic [15:0]   acc_wdata;
  step_t         cur_step;
  logic          script_last;
  logic          in_poll;
  logic          tmo_expired;
  logic          poll_abort;
  logic          b6_same, conf_ok;
  logic          erase_q;

  assign req_ready   = (state == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign cur_step    = script_step(op_q, step);
  assign script_last = (step == script_len(op_q) - 3'd1);
  assign in_poll     = (state == S_POLL);
  assign erase_q     = op_is_erase(op_q);
  assign poll_abort  = in_poll && acc_done && tmo_expired;

  function automatic logic [AW-1:0] pick_addr(asel_e sel, logic [AW-1:0] tgt);
    case (sel)
      AS_KEY1:   return AW'(KEY1_ADDR);
      AS_KEY2:   return AW'(KEY2_ADDR);
      AS_WORD0:  return AW'(0);
      AS_WORD1:  return AW'(1);
      default:   return tgt;
    endcase
  endfunction

  always_comb begin
    acc_we    = 1'b0;
    acc_addr  = addr_q;
    acc_wdata = 16'h0000;
    case (state)
      S_SCRIPT: begin
        acc_we    = cur_step.wr;
        acc_addr  = pick_addr(cur_step.asel, addr_q);
        acc_wdata = cur_step.use_data ? data_q : {8'h00, cur_step.code};
      end
      S_POLL:  acc_addr = (op_q == OP_CHIP) ? AW'(KEY1_ADDR) : addr_q;
      S_ABORT: begin
        acc_we    = 1'b1;
        acc_addr  = AW'(KEY1_ADDR);
        acc_wdata = {8'h00, CMD_RESET};
      end
      default: ;
    endcase
  end

  assign acc_start = !acc_busy &&
                     ((state == S_SCRIPT) || (state == S_POLL) || (state == S_ABORT));

  flash_seq_access #(.AW(AW), .ACC_CLKS(ACC_CLKS)) u_access (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (acc_start),
    .we       (acc_we),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .busy     (acc_busy),
    .last     (acc_done),
    .bus_cs   (bus_cs),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
  );

  flash_seq_timer #(.TO_PROG(TO_PROG), .TO_ERASE(TO_ERASE), .TO_CHIP(TO_CHIP)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_poll),
    .cls    (tmo_class(op_q)),
    .expired(tmo_expired)
  );

  flash_seq_status u_status (
    .cur    (bus_rdata),
    .prev   (prev_q),
    .erase  (erase_q),
    .want7  (data_q[7]),
    .b6_same(b6_same),
    .conf_ok(conf_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      prev_q <= '0;
      id_lo  <= '0;
      id_hi  <= '0;
      step   <= '0;
      pphase <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q   <= op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            step   <= '0;
            pphase <= '0;
            err_q  <= 1'b0;
            if (script_len(op_e'(req_op)) == 3'd0) begin
              err_q <= 1'b1;
              state <= S_RESP;
            end else begin
              state <= S_SCRIPT;
            end
          end
        end
        S_SCRIPT: begin
          if (acc_done) begin
            if (op_q == OP_ID && step == 3'd3) id_lo <= bus_rdata;
            if (op_q == OP_ID && step == 3'd4) id_hi <= bus_rdata;
            if (script_last) begin
              state  <= (op_q == OP_ID) ? S_RESP : S_POLL;
              pphase <= '0;
            end else begin
              step <= step + 3'd1;
            end
          end
        end
        S_POLL: begin
          if (acc_done) begin
            prev_q <= bus_rdata;
            if (tmo_expired) begin
              state <= S_ABORT;
            end else begin
              case (pphase)
                2'd0: pphase <= 2'd1;
                2'd1: if (b6_same) pphase <= 2'd2;
                2'd2: pphase <= conf_ok ? 2'd3 : 2'd1;
                default: begin
                  if (conf_ok) state <= S_RESP;
                  else         pphase <= 2'd1;
                end
              endcase
            end
          end
        end
        S_ABORT: begin
          if (acc_done) begin
            err_q <= 1'b1;
            state <= S_RESP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state == S_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_data  = {id_hi, id_lo};

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          bus_cs,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic          poll_abort
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_cs);

  assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_bus_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && $past(bus_cs)) |-> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_err_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  assert_abort_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_abort |=> ##1 (bus_cs && bus_we && bus_wdata == 16'h00F0));

  assert_no_bus_in_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_cs);
endmodule

bind flash_seq flash_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .bus_cs    (bus_cs),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .poll_abort(poll_abort)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int AW  = 18;
  localparam int ACC = 3;
  localparam int TOP = 150;
  localparam int TOE = 300;
  localparam int TOC = 500;
  localparam int K1  = 'h5555;
  localparam int K2  = 'h2AAA;
  localparam logic [15:0] ID_MFR = 16'h00C3;
  localparam logic [15:0] ID_DEV = 16'h5A17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_data = '0;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_data;
  logic          bus_cs, bus_we;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata;

  flash_seq #(.AW(AW), .ACC_CLKS(ACC), .TO_PROG(TOP), .TO_ERASE(TOE), .TO_CHIP(TOC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int vecs = 0;
  int bad  = 0;
  int cyc  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural flash ----------------
  int  cfg_busy  = 0;
  bit  cfg_hang  = 0;
  bit  cfg_stall = 0;
  bit  clr       = 0;

  int  wn, rn, wr_at_first_rd, first_rd_cyc, width;
  int  wa [0:31];
  int  wd [0:31];
  int  ra [0:31];
  int  h_a [0:4];
  int  h_d [0:4];
  bit  busy, is_er, idmode, tog, stall_pend, prev_cs, last_we, bad_width;
  int  busy_left;
  logic [15:0] tdata;
  int  a_i, d_i;

  always_comb begin
    if (busy)        bus_rdata = {tdata[15:8], (is_er ? 1'b0 : ~tdata[7]), tog, tdata[5:0]};
    else if (idmode) bus_rdata = bus_addr[0] ? ID_DEV : ID_MFR;
    else             bus_rdata = tdata;
  end

  always @(posedge clk) begin
    prev_cs <= bus_cs;
    if (clr) begin
      wn <= 0; rn <= 0; wr_at_first_rd <= -1; first_rd_cyc <= 0; width <= 0;
      busy <= 0; idmode <= 0; tog <= 0; stall_pend <= 0; bad_width <= 0;
      tdata <= 16'h1234; is_er <= 0; busy_left <= 0;
      for (int k = 0; k < 5; k++) begin h_a[k] <= -1; h_d[k] <= -1; end
    end else begin
      if (busy && !cfg_hang) begin
        if (busy_left == 0) busy <= 0;
        else busy_left <= busy_left - 1;
      end
      if (bus_cs) width <= width + 1;
      if (bus_cs && !prev_cs) begin
        last_we <= bus_we;
        if (bus_we) begin
          a_i = int'(bus_addr);
          d_i = int'(bus_wdata);
          if (wn < 32) begin wa[wn] <= a_i; wd[wn] <= d_i; end
          wn <= wn + 1;
          if (!busy) begin
            if (d_i == 'hF0) begin
              idmode <= 0;
              for (int k = 0; k < 5; k++) begin h_a[k] <= -1; h_d[k] <= -1; end
            end else if (h_a[2] == K1 && h_d[2] == 'hAA && h_a[3] == K2 && h_d[3] == 'h55 &&
                         h_a[4] == K1 && h_d[4] == 'hA0) begin
              busy <= 1; busy_left <= cfg_busy; is_er <= 0; tdata <= bus_wdata;
              tog <= 0; stall_pend <= cfg_stall;
              for (int k = 0; k < 5; k++) begin h_a[k] <= -1; h_d[k] <= -1; end
            end else if (h_a[0] == K1 && h_d[0] == 'hAA && h_a[1] == K2 && h_d[1] == 'h55 &&
                         h_a[2] == K1 && h_d[2] == 'h80 && h_a[3] == K1 && h_d[3] == 'hAA &&
                         h_a[4] == K2 && h_d[4] == 'h55 &&
                         (d_i == 'h30 || d_i == 'h50 || (d_i == 'h10 && a_i == K1))) begin
              busy <= 1; busy_left <= cfg_busy; is_er <= 1; tdata <= 16'hFFFF;
              tog <= 0; stall_pend <= cfg_stall;
              for (int k = 0; k < 5; k++) begin h_a[k] <= -1; h_d[k] <= -1; end
            end else if (h_a[3] == K1 && h_d[3] == 'hAA && h_a[4] == K2 && h_d[4] == 'h55 &&
                         a_i == K1 && d_i == 'h90) begin
              idmode <= 1;
              for (int k = 0; k < 5; k++) begin h_a[k] <= -1; h_d[k] <= -1; end
            end else begin
              for (int k = 0; k < 4; k++) begin h_a[k] <= h_a[k+1]; h_d[k] <= h_d[k+1]; end
              h_a[4] <= a_i; h_d[4] <= d_i;
            end
          end
        end else begin
          if (rn == 0) begin wr_at_first_rd <= wn; first_rd_cyc <= cyc; end
          if (rn < 32) ra[rn] <= int'(bus_addr);
          rn <= rn + 1;
        end
      end
      if (!bus_cs && prev_cs) begin
        if (width != ACC) bad_width <= 1;
        width <= 0;
        if (!last_we && busy) begin
          if (stall_pend) stall_pend <= 0;
          else tog <= ~tog;
        end
      end
    end
  end

  // ---------------- expected write log ----------------
  int exp_n;
  int exp_a [0:7];
  int exp_d [0:7];

  task automatic push(input int a, input int d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic build_exp(input int op, input int addr, input int data, input bit abort);
    exp_n = 0;
    push(K1, 'hAA); push(K2, 'h55);
    if (op == 0) begin
      push(K1, 'hA0); push(addr, data);
    end else if (op == 4) begin
      push(K1, 'h90); push(K1, 'hF0);
    end else begin
      push(K1, 'h80); push(K1, 'hAA); push(K2, 'h55);
      if (op == 1)      push(addr, 'h30);
      else if (op == 2) push(addr, 'h50);
      else              push(K1, 'h10);
    end
    if (abort) push(K1, 'hF0);
  endtask

  task automatic check_log(input string req);
    chk(wn == exp_n, req, "write count", wn, exp_n);
    for (int i = 0; i < exp_n && i < wn; i++) begin
      chk(wa[i] == exp_a[i], req, $sformatf("write %0d addr", i), wa[i], exp_a[i]);
      chk(wd[i] == exp_d[i], req, $sformatf("write %0d data", i), wd[i], exp_d[i]);
    end
  endtask

  // ---------------- request driver ----------------
  task automatic run(input int op, input int addr, input int data, input int busyc,
                     input bit hang, input bit stall, input bit nag,
                     output bit err, output logic [31:0] rdat, output int dt, output bit seen);
    int n;
    @(negedge clk);
    cfg_busy = busyc; cfg_hang = hang; cfg_stall = stall; clr = 1;
    @(negedge clk);
    clr = 0;
    req_op = op[2:0]; req_addr = addr[AW-1:0]; req_data = data[15:0]; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R8", "ready after accept", req_ready, 0);
    n = 0;
    while (!rsp_valid && n < 20000) begin
      if (nag && n >= 4 && n < 8) begin
        req_valid = 1; req_op = 3'd3;
        chk(req_ready == 0, "R8", "ready while busy", req_ready, 0);
      end else begin
        req_valid = 0;
      end
      @(negedge clk);
      n++;
    end
    req_valid = 0;
    seen = rsp_valid;
    err  = rsp_err;
    rdat = rsp_data;
    dt   = cyc - first_rd_cyc;
    chk(seen, "R11", "response seen", seen, 1);
    @(negedge clk);
    chk(!rsp_valid && !rsp_err, "R11", "response one cycle", rsp_valid, 0);
    chk(req_ready == 1, "R8", "ready after response", req_ready, 1);
    chk(!bad_width, "R9", "access width", bad_width, 0);
  endtask

  task automatic check_polls(input string req, input int paddr, input int nwr);
    chk(wr_at_first_rd == nwr, req, "writes before first read", wr_at_first_rd, nwr);
    for (int i = 0; i < rn && i < 32; i++)
      chk(ra[i] == paddr, req, $sformatf("poll %0d addr", i), ra[i], paddr);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    bit          err, seen;
    logic [31:0] rdat;
    int          dt;
    int          pdata [0:5];
    int          pbusy [0:2];
    pdata = '{'h0000, 'h00FF, 'h1280, 'hA55A, 'h7F7F, 'hFFFF};
    pbusy = '{0, 25, 61};

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "ready in reset", req_ready, 1);
    chk(bus_cs == 0,    "R1", "cs in reset", bus_cs, 0);
    chk(rsp_valid == 0, "R1", "rsp in reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && bus_cs == 0 && rsp_valid == 0, "R1", "idle after reset",
        {req_ready, bus_cs, rsp_valid}, 3'b100);

    // R2 R4 R5: program sweep over data and busy length, stall on odd entries
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 3; j++) begin
        int addr;
        bit st;
        addr = 'h00100 + i * 'h5031 + j * 7;
        st   = (pbusy[j] > 0) && ((i + j) % 2 == 1);
        run(0, addr, pdata[i], pbusy[j], 0, st, 0, err, rdat, dt, seen);
        chk(err == 0, "R5", "program ok", err, 0);
        chk(busy == 0, "R5", "device idle at success", busy, 0);
        build_exp(0, addr, pdata[i], 0);
        check_log("R2");
        check_polls("R4", addr, 4);
      end
    end

    // R3 R4 R5: erase kinds
    for (int k = 1; k <= 3; k++) begin
      for (int j = 0; j < 2; j++) begin
        int addr;
        int paddr;
        addr  = (k == 2) ? 'h38000 : 'h12800 + j * 'h800;
        paddr = (k == 3) ? K1 : addr;
        run(k, addr, 0, 40 + j * 80 + k * 10, 0, j == 1, 0, err, rdat, dt, seen);
        chk(err == 0, "R5", "erase ok", err, 0);
        chk(busy == 0, "R5", "erase device idle", busy, 0);
        build_exp(k, addr, 0, 0);
        check_log("R3");
        check_polls("R4", paddr, 6);
      end
    end

    // R7 identification
    run(4, 'h2222, 0, 0, 0, 0, 0, err, rdat, dt, seen);
    chk(err == 0, "R7", "id ok", err, 0);
    chk(rdat == {ID_DEV, ID_MFR}, "R7", "id words", rdat, {ID_DEV, ID_MFR});
    chk(rn == 2, "R7", "id read count", rn, 2);
    chk(ra[0] == 0 && ra[1] == 1, "R7", "id read addresses", {ra[0][3:0], ra[1][3:0]}, 8'h01);
    chk(wr_at_first_rd == 3, "R7", "id reads after entry", wr_at_first_rd, 3);
    chk(idmode == 0, "R7", "id mode left", idmode, 0);
    build_exp(4, 0, 0, 0);
    check_log("R7");

    // R6 timeouts per class
    run(0, 'h0ABC, 'h4321, 0, 1, 0, 0, err, rdat, dt, seen);
    chk(err == 1, "R6", "program timeout err", err, 1);
    chk(dt >= TOP - 2 && dt <= TOP + 16, "R6", "program timeout window", dt, TOP);
    build_exp(0, 'h0ABC, 'h4321, 1);
    check_log("R6");
    run(1, 'h1F800, 0, 0, 1, 0, 0, err, rdat, dt, seen);
    chk(err == 1, "R6", "sector timeout err", err, 1);
    chk(dt >= TOE - 2 && dt <= TOE + 16, "R6", "sector timeout window", dt, TOE);
    build_exp(1, 'h1F800, 0, 1);
    check_log("R6");
    run(3, 0, 0, 0, 1, 0, 0, err, rdat, dt, seen);
    chk(err == 1, "R6", "array timeout err", err, 1);
    chk(dt >= TOC - 2 && dt <= TOC + 16, "R6", "array timeout window", dt, TOC);
    build_exp(3, 0, 0, 1);
    check_log("R6");

    // R10 bad codes
    for (int c = 5; c <= 7; c++) begin
      run(c, 'h55, 'h66, 0, 0, 0, 0, err, rdat, dt, seen);
      chk(err == 1, "R10", "bad code err", err, 1);
      chk(wn == 0 && rn == 0, "R10", "no bus access", wn + rn, 0);
    end

    // R8 request held while busy is ignored
    run(0, 'h3000, 'h0180, 50, 0, 0, 1, err, rdat, dt, seen);
    chk(err == 0, "R8", "program with extra request ok", err, 0);
    build_exp(0, 'h3000, 'h0180, 0);
    check_log("R8");
    repeat (4) @(negedge clk);
    chk(bus_cs == 0 && req_ready == 1, "R8", "no late start", {bus_cs, req_ready}, 2'b01);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule